// File: doc/BRIEF.md
# Two-Stage Selectable Fan-In Register Path

This block is the return path of a four-way multiplexing transceiver, built as synchronous logic. There are several bit lanes. Each lane has one input storage cell for each of four source ways. Every cell is a hybrid latch and register. A cell follows its input while its own latch enable is high. Otherwise it loads when a qualified edge arrives on a sampled transfer clock.

A two-bit select picks one way per lane. The selected value feeds an output cell of the same hybrid kind, which has its own latch enable and clock enable. The result goes to the lane output. An active-low output enable is sampled and reported as a drive flag, so the surrounding logic can place the output in a high-impedance state.

The transfer clock is an ordinary input. It is sampled on the system clock. A rising edge is recognised in the system cycle where the sample is high and the previous sample was low. Both storage stages act on that same system edge, so the output stage takes the value the selected cell held before the edge.

Top module: `ftr_fanin`

## Requirements
- R1: Synchronous reset clears every input cell, the output cell, the edge history and the drive flag to 0.
- R2: While `cell_le[w]` is 1 in a cycle, cell way w loads its input slice at that clock edge, whatever `xfer_clk` and `cell_ce_n` are.
- R3: A transfer edge is seen in a cycle where `xfer_clk` is 1 and its sample from the previous cycle was 0. On such an edge with `cell_ce_n` at 0, every cell whose latch enable is 0 loads its input.
- R4: A cell whose latch enable is 0 keeps its value when there is no transfer edge, or when `cell_ce_n` is 1.
- R5: The `sel` values 0, 1, 2 and 3 pick ways 0, 1, 2 and 3. Way w of lane l is input bit `w*LANES+l`.
- R6: While `out_le` is 1, the output cell loads the selected cell value, and `a_data` shows it one cycle later.
- R7: On a transfer edge with `out_le` at 0 and `out_ce_n` at 0, the output cell loads the selected value as it was before that same edge.
- R8: With `out_le` at 0, the output cell holds when there is no transfer edge or when `out_ce_n` is 1.
- R9: `a_drive` equals the inverse of `oe_n` one cycle later. `oe_n` never changes `a_data`.
- R10: Lanes are independent: each bit of `a_data` depends only on the input bits of its own lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| b_data | input | WAYS*LANES | Way inputs; way w, lane l at bit w*LANES+l |
| cell_le | input | WAYS | Per-way latch enable of the input cells |
| xfer_clk | input | 1 | Sampled transfer clock |
| cell_ce_n | input | 1 | Active-low clock enable shared by the input cells |
| sel | input | 2 | Way select |
| out_le | input | 1 | Latch enable of the output cell |
| out_ce_n | input | 1 | Active-low clock enable of the output cell |
| oe_n | input | 1 | Active-low output enable |
| a_data | output | LANES | Registered lane output |
| a_drive | output | 1 | High when the output should be driven |

## Verification
A corrupted input cell is hidden until `sel` points at it. It then shows on `a_data` one cycle later when the output latch is open, or at the next qualified transfer edge otherwise. A wrong edge history shows up as a load one cycle early or late, or as a double load, at the first clocked transfer. An off-by-one in the select mapping shows in every transparent cycle. The reference model compares every cycle under each select value with transparent, clocked and held cells, and any of these faults appears within a few cycles of the stimulus that exposes it.

// File: rtl/ftr_pkg.sv
package ftr_pkg;
  typedef struct packed {
    logic le;
    logic ce_n;
  } stage_ctl_t;

  function automatic logic stage_load(input stage_ctl_t c, input logic rise);
    return c.le | (rise & ~c.ce_n);
  endfunction
endpackage

// File: rtl/ftr_edge.sv
module ftr_edge (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  output logic rise
);
  logic smp_q;

  always_ff @(posedge clk) begin
    if (rst) smp_q <= 1'b0;
    else     smp_q <= smp;
  end

  assign rise = smp & ~smp_q;

  assert_edge_single_R3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/ftr_cell_bank.sv
module ftr_cell_bank #(
  parameter int LANES = 4,
  parameter int WAYS  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WAYS*LANES-1:0]  d,
  input  logic [WAYS-1:0]        le,
  input  logic                   rise,
  input  logic                   ce_n,
  output logic [WAYS*LANES-1:0]  q
);
  import ftr_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    stage_ctl_t ctl;
    assign ctl = '{le: le[w], ce_n: ce_n};

    always_ff @(posedge clk) begin
      if (rst)                        q[w*LANES +: LANES] <= '0;
      else if (stage_load(ctl, rise)) q[w*LANES +: LANES] <= d[w*LANES +: LANES];
    end

    assert_cell_transparent_R2: assert property (@(posedge clk) disable iff (rst)
      le[w] |=> q[w*LANES +: LANES] == $past(d[w*LANES +: LANES]));
    assert_cell_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!le[w] && !(rise && !ce_n)) |=> $stable(q[w*LANES +: LANES]));
  end
endmodule

// File: rtl/ftr_sel.sv
module ftr_sel #(
  parameter int LANES = 4,
  parameter int WAYS  = 4,
  localparam int SW   = $clog2(WAYS)
) (
  input  logic [WAYS*LANES-1:0] cells,
  input  logic [SW-1:0]         sel,
  output logic [LANES-1:0]      p
);
  always_comb begin
    p = '0;
    for (int w = 0; w < WAYS; w++)
      if (sel == SW'(w)) p = cells[w*LANES +: LANES];
  end
endmodule

// File: rtl/ftr_out_stage.sv
module ftr_out_stage #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] p,
  input  logic             le,
  input  logic             ce_n,
  input  logic             rise,
  input  logic             oe_n,
  output logic [LANES-1:0] q,
  output logic             drive
);
  import ftr_pkg::*;
  stage_ctl_t ctl;
  assign ctl = '{le: le, ce_n: ce_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      drive <= 1'b0;
    end else begin
      if (stage_load(ctl, rise)) q <= p;
      drive <= ~oe_n;
    end
  end

  assert_out_transparent_R6: assert property (@(posedge clk) disable iff (rst)
    le |=> q == $past(p));
  assert_out_clocked_R7: assert property (@(posedge clk) disable iff (rst)
    (!le && rise && !ce_n) |=> q == $past(p));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!le && !(rise && !ce_n)) |=> $stable(q));
  assert_drive_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drive == !$past(oe_n));
endmodule

// File: rtl/ftr_fanin.sv
module ftr_fanin #(
  parameter int LANES = 4,
  parameter int WAYS  = 4,
  localparam int SW   = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WAYS*LANES-1:0] b_data,
  input  logic [WAYS-1:0]       cell_le,
  input  logic                  xfer_clk,
  input  logic                  cell_ce_n,
  input  logic [SW-1:0]         sel,
  input  logic                  out_le,
  input  logic                  out_ce_n,
  input  logic                  oe_n,
  output logic [LANES-1:0]      a_data,
  output logic                  a_drive
);
  logic                  rise;
  logic [WAYS*LANES-1:0] cells;
  logic [LANES-1:0]      p;

  ftr_edge u_edge (.clk(clk), .rst(rst), .smp(xfer_clk), .rise(rise));

  ftr_cell_bank #(.LANES(LANES), .WAYS(WAYS)) u_cells (
    .clk(clk), .rst(rst), .d(b_data), .le(cell_le),
    .rise(rise), .ce_n(cell_ce_n), .q(cells));

  ftr_sel #(.LANES(LANES), .WAYS(WAYS)) u_sel (.cells(cells), .sel(sel), .p(p));

  ftr_out_stage #(.LANES(LANES)) u_out (
    .clk(clk), .rst(rst), .p(p), .le(out_le), .ce_n(out_ce_n),
    .rise(rise), .oe_n(oe_n), .q(a_data), .drive(a_drive));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (a_data == '0 && !a_drive));
endmodule

// File: tb/tb_ftr_fanin.sv
module tb_ftr_fanin;
  localparam int LANES = 4;
  localparam int WAYS  = 4;
  localparam int N     = WAYS * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]     b_data = '0;
  logic [WAYS-1:0]  cell_le = '0;
  logic             xfer_clk = 1'b0, cell_ce_n = 1'b1;
  logic [1:0]       sel = '0;
  logic             out_le = 1'b0, out_ce_n = 1'b1, oe_n = 1'b1;
  logic [LANES-1:0] a_data;
  logic             a_drive;

  ftr_fanin #(.LANES(LANES), .WAYS(WAYS)) dut (
    .clk(clk), .rst(rst), .b_data(b_data), .cell_le(cell_le),
    .xfer_clk(xfer_clk), .cell_ce_n(cell_ce_n), .sel(sel),
    .out_le(out_le), .out_ce_n(out_ce_n), .oe_n(oe_n),
    .a_data(a_data), .a_drive(a_drive));

  always #5 clk = ~clk;

  typedef struct {
    logic [LANES-1:0] d;
    logic             v;
    string            tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [LANES-1:0] m_cell [WAYS];
  logic [LANES-1:0] m_a = '0;
  logic             m_drv = 1'b0;
  logic             m_bq = 1'b0;

  task automatic cyc(input logic r, input logic [N-1:0] b, input logic [WAYS-1:0] le,
                     input logic bc, input logic cce, input logic [1:0] s,
                     input logic ole, input logic oce, input logic oen, input string tag);
    logic rise;
    logic [LANES-1:0] pv;
    exp_t e;
    @(negedge clk);
    rst = r; b_data = b; cell_le = le; xfer_clk = bc; cell_ce_n = cce;
    sel = s; out_le = ole; out_ce_n = oce; oe_n = oen;
    if (r) begin
      for (int w = 0; w < WAYS; w++) m_cell[w] = '0;
      m_a = '0; m_drv = 1'b0; m_bq = 1'b0;
    end else begin
      rise = bc & ~m_bq;
      pv = m_cell[s];
      for (int w = 0; w < WAYS; w++)
        if (le[w] || (rise && !cce)) m_cell[w] = b[w*LANES +: LANES];
      if (ole || (rise && !oce)) m_a = pv;
      m_drv = ~oen;
      m_bq = bc;
    end
    e.d = m_a; e.v = m_drv; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (a_data !== e.d || a_drive !== e.v) begin
        errors++;
        $display("FAIL %s: a_data=%h a_drive=%b expected a_data=%h a_drive=%b",
                 e.tag, a_data, a_drive, e.d, e.v);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [N-1:0] pat(input int k);
    return N'(32'h9E37_79B9 * (k + 1) ^ (k << 5));
  endfunction

  initial begin
    logic [N-1:0] v;
    for (int i = 0; i < 3; i++) cyc(1, '1, '1, 1, 0, 0, 1, 0, 0, "R1");
    // R2 R5: transparent cells per select, open output latch
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 3; k++)
        cyc(0, pat(s*3+k), '1, k[0], 1, 2'(s), 1, 1, 0, "R2_R5");
    // R2: only one way open
    for (int s = 0; s < 4; s++) begin
      cyc(0, pat(40+s), 4'b1 << s, 0, 1, 2'(s), 1, 1, 0, "R2");
      cyc(0, pat(50+s), 4'b0, 0, 1, 2'(s), 1, 1, 0, "R2");
      cyc(0, pat(50+s), 4'b0, 0, 1, 2'(s), 1, 1, 0, "R2");
    end
    // R3: clocked load of all cells, then read each way
    cyc(0, pat(60), '0, 0, 0, 0, 1, 1, 0, "R3");
    cyc(0, pat(61), '0, 1, 0, 0, 1, 1, 0, "R3");
    cyc(0, pat(62), '0, 1, 0, 0, 1, 1, 0, "R3");
    for (int s = 0; s < 4; s++) cyc(0, pat(63), '0, 1, 0, 2'(s), 1, 1, 0, "R3_R5");
    // R4: held cells, edges with enable off and no edges with enable on
    for (int k = 0; k < 6; k++) cyc(0, pat(70+k), '0, k[0], 1, 2'(k), 1, 1, 0, "R4");
    for (int k = 0; k < 4; k++) cyc(0, pat(80+k), '0, 1, 0, 2'(k), 1, 1, 0, "R4");
    // R7: output clocked, cells also clocked on same edge
    for (int k = 0; k < 8; k++) cyc(0, pat(90+k), '0, k[0], 0, 2'(k/2), 0, 0, 0, "R7");
    // R8: output holds
    for (int k = 0; k < 6; k++) cyc(0, pat(100+k), '1, k[0], 0, 2'(k), 0, 1, 0, "R8");
    for (int k = 0; k < 4; k++) cyc(0, pat(110+k), '1, 1, 0, 2'(k), 0, 0, 0, "R8");
    // R6: output latch opens
    for (int k = 0; k < 4; k++) cyc(0, pat(120+k), '1, 0, 1, 2'(k), 1, 1, 0, "R6");
    // R9: output enable toggling
    for (int k = 0; k < 6; k++) cyc(0, pat(130+k), '1, 0, 1, 2'(k), 1, 1, k[0], "R9");
    // R10: mixed random traffic
    for (int k = 0; k < 400; k++) begin
      v = N'($urandom);
      cyc(0, v, 4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
          1'($urandom), 1'($urandom), 1'($urandom), "R10");
    end
    cyc(1, '0, '0, 0, 1, 0, 0, 1, 1, "R1");
    cyc(0, '0, '0, 0, 1, 0, 0, 1, 1, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule